// File: doc/BRIEF.md
# Serial Read Port for Metering Registers

This block is a read-only serial slave. It gives a host access to four 24-bit measurement words over four signals: an active-high select, a serial clock, a serial data input and a serial data output. The measurement words arrive at the block as one parallel bus. The block does not compute them.

All serial inputs pass through synchronizers into the system clock domain, and serial clock edges are detected there. The system clock must therefore run at least four times faster than the serial clock.

A transaction starts when select goes high. The host then clocks in nine bits on rising serial clock edges: a fixed header, followed by a six-bit address. After that, the block shifts the addressed word out MSB first on falling edges. It then moves straight on to the following words, wrapping from the last back to the first, and stops only when select is released.

Top module: `spi_meter_reader`

## Requirements
- R1: While select is low, and during reset, `sdo_o` is low and the command and data counters are cleared. Serial clock and data activity while select is low has no effect on `sdo_o`.
- R2: While select is high, `sdi_i` is sampled on rising edges of `sclk_i`. Nine bits are taken: the header bits 1, 1, 0 in that order, then address bits A5 down to A0.
- R3: The word index is taken from A1:A0. Index 0 is active energy, 1 is reactive energy, 2 is voltage and 3 is frequency. These are bits [23:0], [47:24], [71:48] and [95:72] of `meas_words_i`. Address bits A5 to A2 do not affect which word is selected.
- R4: `sdo_o` stays low until the first falling `sclk_i` edge after A0 is captured. That edge presents bit 23 of the selected word, and each later falling edge presents the next lower bit, down to bit 0.
- R5: After bit 0 of a word, the next falling edge presents bit 23 of the word at the next index, with index 3 followed by index 0. This continues until select goes low.
- R6: If the three header bits are not 1, 1, 0, `sdo_o` stays low for the rest of the transaction, whatever happens on `sclk_i` and `sdi_i`.
- R7: Each word is captured from `meas_words_i` when its bit 23 is launched. A change of the input while the word is shifting affects only later readings of that index.
- R8: Dropping select in the middle of a word ends the transaction. The next transaction decodes a fresh header and address and starts from bit 23.
- R9: While select is high, `sdo_o` changes only in response to a falling `sclk_i` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Transaction select, active high |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial command and address input |
| sdo_o | output | 1 | Serial data output |
| meas_words_i | input | 96 | Four 24-bit measurement words, index 0 in the low bits |

## Verification
The word capture at a word boundary and a change of the parallel measurement input can fall close together, and the capture must win cleanly. The bench changes a word in the middle of its own shift-out. It expects the remainder of that word to carry the old value, and the same index to return the new value when the stream wraps back to it four words later.

A second coincidence is a select drop in the middle of a word. The bench checks that the output falls low, and that the next command starts a fresh word rather than resuming the interrupted one.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam int PRE_LEN = 3;
  localparam logic [PRE_LEN-1:0] PRE_CODE = 3'b110;

  typedef enum logic [1:0] {
    SH_WAIT   = 2'd0,
    SH_STREAM = 2'd1,
    SH_MUTE   = 2'd2
  } sh_state_e;
endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg[g] <= '0;
      end else if (g == 0) begin
        stg[g] <= async_i;
      end else begin
        stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/spi_rd_cmd.sv
module spi_rd_cmd
  import spi_rd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_s,
  input  logic             sck_rise,
  input  logic             sdi_s,
  output logic             cmd_done,
  output logic             hdr_ok,
  output logic [IDX_W-1:0] word_idx
);
  localparam int CMD_LEN = PRE_LEN + ADDR_W;
  localparam int CNT_W   = $clog2(CMD_LEN + 1);

  logic [CMD_LEN-1:0] cmd_sr;
  logic [CNT_W-1:0]   bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_sr  <= '0;
      bit_cnt <= '0;
    end else if (!sel_s) begin
      cmd_sr  <= '0;
      bit_cnt <= '0;
    end else if (sck_rise && (bit_cnt != CNT_W'(CMD_LEN))) begin
      cmd_sr  <= {cmd_sr[CMD_LEN-2:0], sdi_s};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign cmd_done = (bit_cnt == CNT_W'(CMD_LEN));
  assign hdr_ok   = (cmd_sr[CMD_LEN-1 -: PRE_LEN] == PRE_CODE);
  assign word_idx = cmd_sr[IDX_W-1:0];
endmodule

// File: rtl/spi_rd_shift.sv
module spi_rd_shift
  import spi_rd_pkg::*;
#(
  parameter int WORD_W   = 24,
  parameter int NUM_REGS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sel_s,
  input  logic                         sck_fall,
  input  logic                         cmd_done,
  input  logic                         hdr_ok,
  input  logic [$clog2(NUM_REGS)-1:0]  start_idx,
  input  logic [NUM_REGS*WORD_W-1:0]   words_i,
  output logic                         sdo,
  output logic                         streaming,
  output logic                         muted
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] words [NUM_REGS];
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    assign words[g] = words_i[g*WORD_W +: WORD_W];
  end

  sh_state_e         st;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  left;
  logic [WORD_W-1:0] sh;
  logic [IDX_W-1:0]  idx_nxt;

  assign idx_nxt = (idx == IDX_W'(NUM_REGS-1)) ? '0 : idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SH_WAIT;
      idx  <= '0;
      left <= '0;
      sh   <= '0;
      sdo  <= 1'b0;
    end else if (!sel_s) begin
      st   <= SH_WAIT;
      idx  <= '0;
      left <= '0;
      sh   <= '0;
      sdo  <= 1'b0;
    end else begin
      case (st)
        SH_WAIT: begin
          if (cmd_done) begin
            st   <= hdr_ok ? SH_STREAM : SH_MUTE;
            idx  <= start_idx;
            left <= '0;
          end
        end
        SH_STREAM: begin
          if (sck_fall) begin
            if (left == '0) begin
              sdo  <= words[idx][WORD_W-1];
              sh   <= {words[idx][WORD_W-2:0], 1'b0};
              left <= CNT_W'(WORD_W-1);
              idx  <= idx_nxt;
            end else begin
              sdo  <= sh[WORD_W-1];
              sh   <= {sh[WORD_W-2:0], 1'b0};
              left <= left - 1'b1;
            end
          end
        end
        default: sdo <= 1'b0;
      endcase
    end
  end

  assign streaming = (st == SH_STREAM);
  assign muted     = (st == SH_MUTE);
endmodule

// File: rtl/spi_meter_reader.sv
module spi_meter_reader #(
  parameter int WORD_W      = 24,
  parameter int NUM_REGS    = 4,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel_i,
  input  logic                       sclk_i,
  input  logic                       sdi_i,
  output logic                       sdo_o,
  input  logic [NUM_REGS*WORD_W-1:0] meas_words_i
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [2:0]       raw_in, syn_in;
  logic             sel_s, sck_s, sdi_s, sck_q;
  logic             sck_rise, sck_fall;
  logic             cmd_done, hdr_ok, streaming, muted;
  logic [IDX_W-1:0] start_idx;

  assign raw_in = {sel_i, sclk_i, sdi_i};

  spi_rd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(syn_in)
  );

  assign {sel_s, sck_s, sdi_s} = syn_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;

  spi_rd_cmd #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_cmd (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .sck_rise(sck_rise),
    .sdi_s(sdi_s), .cmd_done(cmd_done), .hdr_ok(hdr_ok),
    .word_idx(start_idx)
  );

  spi_rd_shift #(.WORD_W(WORD_W), .NUM_REGS(NUM_REGS)) i_shift (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .sck_fall(sck_fall),
    .cmd_done(cmd_done), .hdr_ok(hdr_ok), .start_idx(start_idx),
    .words_i(meas_words_i), .sdo(sdo_o), .streaming(streaming),
    .muted(muted)
  );
endmodule

// File: rtl/spi_rd_chk.sv
module spi_rd_chk (
  input logic clk,
  input logic rst_n,
  input logic sel_s,
  input logic sck_fall,
  input logic sdo,
  input logic streaming,
  input logic muted,
  input logic cmd_done
);
  // R1: a deselected port drives its output low on the next cycle
  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s |=> !sdo);

  // R6: a rejected header keeps the output low
  p_mute_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_s && muted) |=> !sdo);

  // R9: output moves only on a detected falling serial clock edge
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_s && !sck_fall) |=> $stable(sdo));

  // R2: streaming begins only once the full command has been taken
  p_cmd_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(streaming) |-> cmd_done);
endmodule

bind spi_meter_reader spi_rd_chk i_chk (
  .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .sck_fall(sck_fall),
  .sdo(sdo_o), .streaming(streaming), .muted(muted), .cmd_done(cmd_done)
);

// File: tb/test_spi_meter_reader.sv
module test_spi_meter_reader;
  localparam int W = 24;
  localparam int N = 4;
  localparam int NV = 10;

  // vector: [11:9] header, [8:3] address, [2:0] words to read
  localparam logic [11:0] VEC [NV] = '{
    {3'b110, 6'h00, 3'd1}, {3'b110, 6'h01, 3'd1},
    {3'b110, 6'h02, 3'd1}, {3'b110, 6'h03, 3'd1},
    {3'b110, 6'h03, 3'd3}, {3'b110, 6'h32, 3'd1},
    {3'b110, 6'h0D, 3'd2}, {3'b111, 6'h00, 3'd2},
    {3'b010, 6'h01, 3'd1}, {3'b100, 6'h02, 3'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic sdo;
  logic [W-1:0] regs_tb [N];
  logic [N*W-1:0] meas;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;
  assign meas = {regs_tb[3], regs_tb[2], regs_tb[1], regs_tb[0]};

  spi_meter_reader i_spi_meter_reader (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .meas_words_i(meas)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi = b; half(); sck = 1'b1; half(); sck = 1'b0;
  endtask

  // R2 command shifting, R4 bit order, R5 wrap, R7 snapshot model
  task automatic xfer(input logic [2:0] hdr, input logic [5:0] addr, input int nw,
                      input string req, input int chg_word, input int chg_bit,
                      input logic [W-1:0] chg_val);
    int idx;
    logic stable_ok;
    logic [W-1:0] got, exp;
    sel = 1'b1; half();
    for (int i = 2; i >= 0; i--) send_bit(hdr[i]);
    for (int i = 5; i >= 0; i--) send_bit(addr[i]);
    idx = int'(addr[1:0]);
    stable_ok = 1'b1;
    for (int w = 0; w < nw; w++) begin
      exp = (hdr == 3'b110) ? regs_tb[idx] : '0;
      got = '0;
      for (int b = 0; b < W; b++) begin
        logic s;
        sdi = b[0];
        half();
        s = sdo;
        got = {got[W-2:0], s};
        sck = 1'b1; half();
        if (sdo !== s) stable_ok = 1'b0;
        sck = 1'b0;
        if (w == chg_word && b == chg_bit) regs_tb[idx] = chg_val;
      end
      check(req, got, exp);
      idx = (idx + 1) % N;
    end
    check("R9", {23'd0, stable_ok}, 24'd1);
    sel = 1'b0; half();
    check("R1", {23'd0, sdo}, 24'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    regs_tb[0] = 24'hA5C3F1; regs_tb[1] = 24'h3C0F96;
    regs_tb[2] = 24'h00FF01; regs_tb[3] = 24'h8001FE;
    repeat (4) @(negedge clk);
    check("R1", {23'd0, sdo}, 24'd0);
    rst_n = 1'b1;
    half();

    // R1: activity while deselected leaves the output low
    for (int i = 0; i < 12; i++) send_bit(i[1]);
    check("R1", {23'd0, sdo}, 24'd0);

    for (int v = 0; v < NV; v++) begin
      string req;
      logic [2:0] hdr;
      hdr = VEC[v][11:9];
      if (hdr != 3'b110)        req = "R6";
      else if (VEC[v][2:0] > 1) req = "R5";
      else                      req = "R3 R4";
      xfer(hdr, VEC[v][8:3], int'(VEC[v][2:0]), req, -1, 0, '0);
    end

    // R7: change index 2 mid-word, expect old word now and new one after wrap
    xfer(3'b110, 6'h02, 5, "R7", 0, 5, 24'h5A5A5A);

    // R8: abort mid-word, then a fresh transaction
    sel = 1'b1; half();
    for (int i = 2; i >= 0; i--) send_bit(i != 0);
    for (int i = 5; i >= 0; i--) send_bit(i == 0);
    for (int b = 0; b < 10; b++) begin
      half(); sck = 1'b1; half(); sck = 1'b0;
    end
    sel = 1'b0; half();
    check("R8", {23'd0, sdo}, 24'd0);
    xfer(3'b110, 6'h01, 1, "R8", -1, 0, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule